// File: doc/BRIEF.md
# Banked Register File with Bank Exchange

This block is the 32-entry, byte-wide register file of a small 8-bit controller core. Software sees locations R0 to R31 through a 5-bit address. The lowest twelve addresses form two switchable groups: the lower group covers R0–R3 and the upper group covers R4–R11. Each group has a main copy and an alternate copy, and only one copy of each group is visible at a time. Everything from R12 upwards is a single plain copy. In that range, R12–R19 hold four 16-bit pointers, R20–R27 are general storage, R28–R29 are the timer bytes and R30–R31 are the stack pointers. In this block those last four are only storage.

An exchange strobe carries a 2-bit select. Bit 0 picks the copy of the lower group and bit 1 picks the copy of the upper group, with 1 meaning main and 0 meaning alternate. The core reads operands through two combinational ports. A third read port always shows R8, the accumulator, in whichever upper-group copy is active. The core writes through one byte port. A byte write may be flagged as immediate-form, and such a write may only reach R0–R15. A separate word port loads any of the four pointers at once, and all four pointers are always visible as 16-bit words.

Top module: `swapbank_regfile`

## Requirements
- R1: After reset every location of every bank reads 0x00, all pointer words read 0x0000, and both groups show their alternate copies.
- R2: On a clock edge with `xchg_en` high, the lower group takes the copy named by `xchg_sel[0]` and the upper group takes the copy named by `xchg_sel[1]` (1 = main, 0 = alternate). Without the strobe the selection holds.
- R3: Reads and writes in the same cycle as an exchange use the mapping that was in force before that edge.
- R4: The hidden copy of a group cannot be written through any address, and it keeps its contents across any number of exchanges.
- R5: `acc_data` always equals the value that reading address 8 returns, in the upper-group copy that is currently active.
- R6: When `wr_en` and `wr_imm` are high and `wr_addr` is 16 or more, `imm_fault` is high in that same cycle and no location changes. An immediate write below 16 stores normally.
- R7: Pointer k (0 = R12/R13 through 3 = R18/R19) appears on `ptr_words[16k+15:16k]`, with the even address as the low byte and the odd address as the high byte.
- R8: A pointer write stores `ptr_wr_data` into both bytes of pointer `ptr_wr_idx` at the edge. If the byte port hits one of those bytes in the same cycle, the word value wins.
- R9: With the default setting (no bypass), a read of the address being written in the same cycle returns the old value. The new value appears from the next cycle.
- R10: R12–R31 keep one copy each and behave the same under any bank selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd0_addr | input | 5 | Read port 0 address |
| rd0_data | output | 8 | Read port 0 data (combinational) |
| rd1_addr | input | 5 | Read port 1 address |
| rd1_data | output | 8 | Read port 1 data (combinational) |
| acc_data | output | 8 | Accumulator R8 in the active upper-group copy |
| wr_en | input | 1 | Byte write enable |
| wr_imm | input | 1 | Marks the byte write as immediate-form (limited to R0–R15) |
| wr_addr | input | 5 | Byte write address |
| wr_data | input | 8 | Byte write data |
| imm_fault | output | 1 | Immediate-form write aimed at R16 or above (suppressed) |
| xchg_en | input | 1 | Bank exchange strobe |
| xchg_sel | input | 2 | Bit 0: lower group copy, bit 1: upper group copy; 1 = main |
| ptr_wr_en | input | 1 | Pointer word write enable |
| ptr_wr_idx | input | 2 | Pointer index 0..3 |
| ptr_wr_data | input | 16 | Pointer word value |
| ptr_words | output | 64 | All four pointers, pointer k in bits 16k+15:16k |

## Verification
A wrong bank selection shows at the read ports in the first cycle after the exchange edge, because every access to R0–R11 then returns the other copy's byte. That includes the accumulator port. A write that lands in the wrong copy, or that leaks through a suppressed immediate access, stays hidden until that location is read or that group is switched. For this reason the reference model compares both read ports, the accumulator and all four pointer words on every cycle, and exchanges are mixed into random traffic. A lost pointer word or a wrong byte order shows on `ptr_words` one cycle after the write.

// File: rtl/swapbank_pkg.sv
package swapbank_pkg;

   // Copy selector for one switchable group; reset value is the alternate copy
   typedef enum logic {
      BANK_ALT  = 1'b0,
      BANK_MAIN = 1'b1
   } bank_e;

   // Bit 1 steers the upper group, bit 0 the lower group
   typedef struct packed {
      bank_e grp_b;
      bank_e grp_a;
   } bank_map_t;

   localparam bank_map_t BANK_MAP_RESET = '{grp_b: BANK_ALT, grp_a: BANK_ALT};

endpackage

// File: rtl/swapbank_map.sv
// Logical register address to physical storage slot.
// Physical layout: slots 0..NUM_LOC-1 hold the main copies and all single
// locations; the alternate lower-group copy follows, then the alternate
// upper-group copy.
module swapbank_map
   import swapbank_pkg::*;
#(
   parameter int ADDR_W  = 5,
   parameter int NUM_LOC = 32,
   parameter int GA_LO   = 0,
   parameter int GA_N    = 4,
   parameter int GB_LO   = 4,
   parameter int GB_N    = 8,
   parameter int PHYS_W  = 6
) (
   input  logic [ADDR_W-1:0] addr,
   input  bank_map_t         map,
   output logic [PHYS_W-1:0] phys
);

   localparam int ALT_A_BASE = NUM_LOC;
   localparam int ALT_B_BASE = NUM_LOC + GA_N;

   always_comb begin
      int a;
      int p;
      a = int'(addr);
      p = a;
      if ((a >= GA_LO) && (a < GA_LO + GA_N) && (map.grp_a == BANK_ALT)) begin
         p = ALT_A_BASE + (a - GA_LO);
      end else if ((a >= GB_LO) && (a < GB_LO + GB_N) && (map.grp_b == BANK_ALT)) begin
         p = ALT_B_BASE + (a - GB_LO);
      end
      phys = PHYS_W'(p);
   end

endmodule

// File: rtl/swapbank_store.sv
// Physical byte storage with one byte write and one pointer-word write.
// The word write takes priority on a shared byte.
module swapbank_store #(
   parameter int DATA_W   = 8,
   parameter int PHYS_N   = 44,
   parameter int PHYS_W   = 6,
   parameter int PTR_BASE = 12,
   parameter int PTR_N    = 4,
   parameter int PIDX_W   = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     byte_we,
   input  logic [PHYS_W-1:0]        byte_idx,
   input  logic [DATA_W-1:0]        byte_data,
   input  logic                     word_we,
   input  logic [PIDX_W-1:0]        word_idx,
   input  logic [2*DATA_W-1:0]      word_data,
   output logic [PHYS_N*DATA_W-1:0] mem_q,
   output logic [PHYS_N*DATA_W-1:0] mem_nxt
);

   for (genvar gi = 0; gi < PHYS_N; gi++) begin : g_ent
      logic              word_hit;
      logic [DATA_W-1:0] word_byte;
      logic [DATA_W-1:0] q;
      logic [DATA_W-1:0] nxt;

      if ((gi >= PTR_BASE) && (gi < PTR_BASE + 2*PTR_N)) begin : g_ptr
         localparam int PK = (gi - PTR_BASE) / 2;
         localparam int HB = (gi - PTR_BASE) % 2;
         assign word_hit  = word_we && (int'(word_idx) == PK);
         assign word_byte = word_data[HB*DATA_W +: DATA_W];
      end else begin : g_plain
         assign word_hit  = 1'b0;
         assign word_byte = '0;
      end

      always_comb begin
         if (word_hit) begin
            nxt = word_byte;
         end else if (byte_we && (int'(byte_idx) == gi)) begin
            nxt = byte_data;
         end else begin
            nxt = q;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= '0;
         end else begin
            q <= nxt;
         end
      end

      assign mem_q[gi*DATA_W +: DATA_W]   = q;
      assign mem_nxt[gi*DATA_W +: DATA_W] = nxt;
   end

endmodule

// File: rtl/swapbank_rdport.sv
// Byte select from a flat storage image.
module swapbank_rdport #(
   parameter int DATA_W = 8,
   parameter int PHYS_N = 44,
   parameter int PHYS_W = 6
) (
   input  logic [PHYS_N*DATA_W-1:0] src,
   input  logic [PHYS_W-1:0]        idx,
   output logic [DATA_W-1:0]        data
);

   always_comb begin
      data = '0;
      for (int k = 0; k < PHYS_N; k++) begin
         if (int'(idx) == k) begin
            data = src[k*DATA_W +: DATA_W];
         end
      end
   end

endmodule

// File: rtl/swapbank_regfile.sv
module swapbank_regfile
   import swapbank_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 5,
   parameter int GA_LO     = 0,
   parameter int GA_N      = 4,
   parameter int GB_LO     = 4,
   parameter int GB_N      = 8,
   parameter int ACC_ADDR  = 8,
   parameter int PTR_BASE  = 12,
   parameter int PTR_N     = 4,
   parameter int IMM_LIMIT = 16,
   parameter bit BYPASS    = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ADDR_W-1:0]            rd0_addr,
   output logic [DATA_W-1:0]            rd0_data,
   input  logic [ADDR_W-1:0]            rd1_addr,
   output logic [DATA_W-1:0]            rd1_data,
   output logic [DATA_W-1:0]            acc_data,
   input  logic                         wr_en,
   input  logic                         wr_imm,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [DATA_W-1:0]            wr_data,
   output logic                         imm_fault,
   input  logic                         xchg_en,
   input  logic [1:0]                   xchg_sel,
   input  logic                         ptr_wr_en,
   input  logic [$clog2(PTR_N)-1:0]     ptr_wr_idx,
   input  logic [2*DATA_W-1:0]          ptr_wr_data,
   output logic [PTR_N*2*DATA_W-1:0]    ptr_words
);

   localparam int NUM_LOC = 1 << ADDR_W;
   localparam int PHYS_N  = NUM_LOC + GA_N + GB_N;
   localparam int PHYS_W  = $clog2(PHYS_N);
   localparam int PIDX_W  = $clog2(PTR_N);
   localparam int WORD_W  = 2 * DATA_W;
   localparam int N_RD    = 3;   // rd0, rd1, accumulator

   // Elaboration-time parameter checks
   if (GA_LO + GA_N > GB_LO) begin : g_bad_groups
      $error("swapbank_regfile: lower group overlaps upper group");
   end
   if (GB_LO + GB_N > PTR_BASE) begin : g_bad_ptr
      $error("swapbank_regfile: pointers must sit above the switchable groups");
   end
   if (PTR_BASE + 2*PTR_N > NUM_LOC) begin : g_bad_ptr_top
      $error("swapbank_regfile: pointers exceed the address space");
   end
   if ((ACC_ADDR < GB_LO) || (ACC_ADDR >= GB_LO + GB_N)) begin : g_bad_acc
      $error("swapbank_regfile: accumulator must be in the upper group");
   end
   if ((PTR_N < 2) || ((1 << PIDX_W) != PTR_N)) begin : g_bad_ptr_n
      $error("swapbank_regfile: pointer count must be a power of two >= 2");
   end
   if ((IMM_LIMIT < 1) || (IMM_LIMIT > NUM_LOC)) begin : g_bad_imm
      $error("swapbank_regfile: immediate limit out of range");
   end

   // Bank selection register
   bank_map_t bank_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bank_q <= BANK_MAP_RESET;
      end else if (xchg_en) begin
         bank_q <= bank_map_t'(xchg_sel);
      end
   end

   // Immediate-form range guard
   assign imm_fault = wr_en && wr_imm && (int'(wr_addr) >= IMM_LIMIT);

   // Address mapping: one mapper per read port plus one for the write port
   logic [ADDR_W-1:0] rd_addr [N_RD];
   logic [PHYS_W-1:0] rd_phys [N_RD];
   logic [DATA_W-1:0] rd_val  [N_RD];
   logic [PHYS_W-1:0] wr_phys;

   assign rd_addr[0] = rd0_addr;
   assign rd_addr[1] = rd1_addr;
   assign rd_addr[2] = ADDR_W'(ACC_ADDR);

   swapbank_map #(
      .ADDR_W (ADDR_W), .NUM_LOC(NUM_LOC),
      .GA_LO  (GA_LO),  .GA_N   (GA_N),
      .GB_LO  (GB_LO),  .GB_N   (GB_N),
      .PHYS_W (PHYS_W)
   ) wr_map_i (
      .addr (wr_addr),
      .map  (bank_q),
      .phys (wr_phys)
   );

   // Storage
   logic [PHYS_N*DATA_W-1:0] mem_q;
   logic [PHYS_N*DATA_W-1:0] mem_nxt;
   logic [PHYS_N*DATA_W-1:0] rd_src;

   swapbank_store #(
      .DATA_W  (DATA_W), .PHYS_N(PHYS_N), .PHYS_W(PHYS_W),
      .PTR_BASE(PTR_BASE), .PTR_N(PTR_N), .PIDX_W(PIDX_W)
   ) store_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_we   (wr_en && !imm_fault),
      .byte_idx  (wr_phys),
      .byte_data (wr_data),
      .word_we   (ptr_wr_en),
      .word_idx  (ptr_wr_idx),
      .word_data (ptr_wr_data),
      .mem_q     (mem_q),
      .mem_nxt   (mem_nxt)
   );

   // Bypass option: reads see the value the coming edge will store
   assign rd_src = BYPASS ? mem_nxt : mem_q;

   for (genvar gr = 0; gr < N_RD; gr++) begin : g_rd
      swapbank_map #(
         .ADDR_W (ADDR_W), .NUM_LOC(NUM_LOC),
         .GA_LO  (GA_LO),  .GA_N   (GA_N),
         .GB_LO  (GB_LO),  .GB_N   (GB_N),
         .PHYS_W (PHYS_W)
      ) map_i (
         .addr (rd_addr[gr]),
         .map  (bank_q),
         .phys (rd_phys[gr])
      );

      swapbank_rdport #(
         .DATA_W(DATA_W), .PHYS_N(PHYS_N), .PHYS_W(PHYS_W)
      ) port_i (
         .src  (rd_src),
         .idx  (rd_phys[gr]),
         .data (rd_val[gr])
      );
   end

   assign rd0_data = rd_val[0];
   assign rd1_data = rd_val[1];
   assign acc_data = rd_val[2];

   // Pointer words: single-copy slots, so physical index equals address
   for (genvar gp = 0; gp < PTR_N; gp++) begin : g_ptrw
      localparam int LO_SLOT = PTR_BASE + 2*gp;
      assign ptr_words[gp*WORD_W +: WORD_W] =
         {mem_q[(LO_SLOT+1)*DATA_W +: DATA_W], mem_q[LO_SLOT*DATA_W +: DATA_W]};
   end

endmodule

// File: rtl/swapbank_chk.sv
module swapbank_chk #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 5,
   parameter int ACC_ADDR  = 8,
   parameter int PTR_N     = 4,
   parameter int IMM_LIMIT = 16,
   parameter int PHYS_N    = 44
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [ADDR_W-1:0]           rd0_addr,
   input logic [DATA_W-1:0]           rd0_data,
   input logic [DATA_W-1:0]           acc_data,
   input logic                        wr_en,
   input logic                        wr_imm,
   input logic [ADDR_W-1:0]           wr_addr,
   input logic                        xchg_en,
   input logic [1:0]                  xchg_sel,
   input logic                        ptr_wr_en,
   input logic [$clog2(PTR_N)-1:0]    ptr_wr_idx,
   input logic [2*DATA_W-1:0]         ptr_wr_data,
   input logic [PTR_N*2*DATA_W-1:0]   ptr_words,
   input logic [1:0]                  bank_q,
   input logic [PHYS_N*DATA_W-1:0]    mem_q
);

   localparam int WORD_W = 2 * DATA_W;

   assert_reset_alt_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (bank_q == 2'b00));

   assert_xchg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      xchg_en |=> (bank_q == $past(xchg_sel)));

   assert_xchg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !xchg_en |=> $stable(bank_q));

   assert_acc_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rd0_addr) == ACC_ADDR) |-> (acc_data == rd0_data));

   assert_imm_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_imm && (int'(wr_addr) >= IMM_LIMIT) && !ptr_wr_en)
         |=> (mem_q == $past(mem_q)));

   assert_word_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_wr_en |=> (ptr_words[int'($past(ptr_wr_idx))*WORD_W +: WORD_W] == $past(ptr_wr_data)));

endmodule

bind swapbank_regfile swapbank_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ACC_ADDR(ACC_ADDR),
   .PTR_N(PTR_N), .IMM_LIMIT(IMM_LIMIT), .PHYS_N(PHYS_N)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd0_addr   (rd0_addr),
   .rd0_data   (rd0_data),
   .acc_data   (acc_data),
   .wr_en      (wr_en),
   .wr_imm     (wr_imm),
   .wr_addr    (wr_addr),
   .xchg_en    (xchg_en),
   .xchg_sel   (xchg_sel),
   .ptr_wr_en  (ptr_wr_en),
   .ptr_wr_idx (ptr_wr_idx),
   .ptr_wr_data(ptr_wr_data),
   .ptr_words  (ptr_words),
   .bank_q     (bank_q),
   .mem_q      (mem_q)
);

// File: tb/swapbank_regfile_tb.sv
module swapbank_regfile_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  rd0_addr = '0, rd1_addr = '0, wr_addr = '0;
   logic [7:0]  rd0_data, rd1_data, acc_data, wr_data = '0;
   logic        wr_en = 1'b0, wr_imm = 1'b0, imm_fault;
   logic        xchg_en = 1'b0;
   logic [1:0]  xchg_sel = '0;
   logic        ptr_wr_en = 1'b0;
   logic [1:0]  ptr_wr_idx = '0;
   logic [15:0] ptr_wr_data = '0;
   logic [63:0] ptr_words;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;   // 8 ns period

   swapbank_regfile dut_i (
      .clk(clk), .rst_n(rst_n),
      .rd0_addr(rd0_addr), .rd0_data(rd0_data),
      .rd1_addr(rd1_addr), .rd1_data(rd1_data),
      .acc_data(acc_data),
      .wr_en(wr_en), .wr_imm(wr_imm), .wr_addr(wr_addr), .wr_data(wr_data),
      .imm_fault(imm_fault),
      .xchg_en(xchg_en), .xchg_sel(xchg_sel),
      .ptr_wr_en(ptr_wr_en), .ptr_wr_idx(ptr_wr_idx), .ptr_wr_data(ptr_wr_data),
      .ptr_words(ptr_words)
   );

   // Behavioural reference: visible banks, hidden banks, single copies
   logic [7:0] m_loc   [32];
   logic [7:0] m_alt_a [4];
   logic [7:0] m_alt_b [8];
   bit         a_main, b_main;

   function automatic logic [7:0] m_read(int a);
      if (a < 4 && !a_main) return m_alt_a[a];
      if (a >= 4 && a < 12 && !b_main) return m_alt_b[a-4];
      return m_loc[a];
   endfunction

   function automatic void m_write(int a, logic [7:0] d);
      if (a < 4 && !a_main) m_alt_a[a] = d;
      else if (a >= 4 && a < 12 && !b_main) m_alt_b[a-4] = d;
      else m_loc[a] = d;
   endfunction

   function automatic void m_reset();
      foreach (m_loc[i]) m_loc[i] = 8'h00;
      foreach (m_alt_a[i]) m_alt_a[i] = 8'h00;
      foreach (m_alt_b[i]) m_alt_b[i] = 8'h00;
      a_main = 1'b0;
      b_main = 1'b0;
   endfunction

   task automatic check(string tag, string what, logic [15:0] got, logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // One cycle: inputs are already driven; compare, then advance the model at the edge
   task automatic cyc(string tag);
      bit flt;
      #1;
      flt = wr_en && wr_imm && (int'(wr_addr) >= 16);
      check(tag, "rd0_data", 16'(rd0_data), 16'(m_read(int'(rd0_addr))));
      check(tag, "rd1_data", 16'(rd1_data), 16'(m_read(int'(rd1_addr))));
      check(tag, "acc_data", 16'(acc_data), 16'(m_read(8)));
      check(tag, "imm_fault", 16'(imm_fault), 16'(flt));
      for (int k = 0; k < 4; k++) begin
         check(tag, "ptr_words", ptr_words[16*k +: 16], {m_loc[13+2*k], m_loc[12+2*k]});
      end
      @(posedge clk);
      if (wr_en && !flt) m_write(int'(wr_addr), wr_data);
      if (ptr_wr_en) begin
         m_loc[12 + 2*int'(ptr_wr_idx)] = ptr_wr_data[7:0];
         m_loc[13 + 2*int'(ptr_wr_idx)] = ptr_wr_data[15:8];
      end
      if (xchg_en) begin
         a_main = xchg_sel[0];
         b_main = xchg_sel[1];
      end
      @(negedge clk);
      wr_en = 1'b0; wr_imm = 1'b0; xchg_en = 1'b0; ptr_wr_en = 1'b0;
   endtask

   task automatic bwr(int a, logic [7:0] d, bit imm);
      wr_en = 1'b1; wr_imm = imm; wr_addr = 5'(a); wr_data = d;
   endtask

   task automatic xchg(logic [1:0] s);
      xchg_en = 1'b1; xchg_sel = s;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R1 watchdog: got timeout expected completion");
         report();
      end
   end

   initial begin
      m_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: every address reads zero after reset, alternate banks active
      for (int a = 0; a < 32; a++) begin
         rd0_addr = 5'(a); rd1_addr = 5'(31 - a);
         cyc("R1");
      end

      // R3: write R0 (alternate) in the exchange cycle, reading R0 in that cycle too
      rd0_addr = 0; rd1_addr = 8;
      bwr(0, 8'h11, 1'b0); xchg(2'b01);
      cyc("R3");
      cyc("R2");                       // R0 now shows main copy (zero)
      bwr(0, 8'h22, 1'b0); cyc("R4");  // main R0 written
      xchg(2'b00); cyc("R2");
      cyc("R4");                       // alternate still 0x11
      xchg(2'b01); cyc("R4");
      cyc("R4");                       // main still 0x22

      // R5: accumulator follows upper-group copy
      rd0_addr = 8;
      bwr(8, 8'hA5, 1'b0); cyc("R5");  // alternate B R8
      xchg(2'b11); cyc("R5");
      cyc("R5");                       // main R8 zero
      bwr(8, 8'h3C, 1'b0); cyc("R5");
      xchg(2'b01); cyc("R5");
      cyc("R5");                       // back to 0xA5

      // R6: immediate write at and above the limit
      rd0_addr = 20; rd1_addr = 15;
      bwr(20, 8'hEE, 1'b1); cyc("R6");
      cyc("R6");
      bwr(16, 8'hEF, 1'b1); rd0_addr = 16; cyc("R6");
      cyc("R6");
      bwr(15, 8'h77, 1'b1); cyc("R6");
      cyc("R6");

      // R9: same-cycle read of a write target returns old value
      rd0_addr = 20; rd1_addr = 20;
      bwr(20, 8'h5A, 1'b0); cyc("R9");
      cyc("R9");

      // R7 and R8: pointer words, byte order, and word priority
      rd0_addr = 16; rd1_addr = 17;
      ptr_wr_en = 1'b1; ptr_wr_idx = 2; ptr_wr_data = 16'hBEEF; cyc("R8");
      cyc("R7");
      bwr(19, 8'h44, 1'b0); cyc("R7");
      rd0_addr = 14; rd1_addr = 15;
      bwr(14, 8'h99, 1'b0);
      ptr_wr_en = 1'b1; ptr_wr_idx = 1; ptr_wr_data = 16'h1234; cyc("R8");
      cyc("R8");

      // R10 and general: random traffic mixed with exchanges
      for (int i = 0; i < 800; i++) begin
         rd0_addr = 5'($urandom_range(0, 31));
         rd1_addr = 5'($urandom_range(0, 31));
         if ($urandom_range(0, 1) == 1) begin
            bwr($urandom_range(0, 31), 8'($urandom), ($urandom_range(0, 3) == 0));
         end
         if ($urandom_range(0, 7) == 0) xchg(2'($urandom));
         if ($urandom_range(0, 5) == 0) begin
            ptr_wr_en = 1'b1;
            ptr_wr_idx = 2'($urandom);
            ptr_wr_data = 16'($urandom);
         end
         cyc("R10");
      end

      done = 1'b1;
      report();
   end

endmodule